// File: doc/BRIEF.md
# Timecode Card Status Decoder

This block turns the four 32-bit status words read back from an optional timecode card into decoded fields. It first checks a fixed marker pattern spread across the words to decide whether a card is fitted at all. When the card is present, it converts the four time-of-day fields from packed BCD to binary, flags any digit that is not decimal, and reports the frame-rate code, the drop-frame flag, the video standard flags, the two input-valid flags and the lock flag. It also reassembles a 14-bit PLL phase count from two 7-bit pieces.

The reassembled phase feeds a sequential restoring divider, which turns it into an estimate of the incoming frequency: a fixed constant of 400,000,000 divided by the phase, one quotient bit per clock. The decoded fields appear one cycle after the load strobe. The frequency estimate follows when the divider finishes. When there is nothing to divide, the frequency result appears at once.

A host-side bus agent fetches the four words and pulses `load` with the words on the word inputs. It reads the decoded result when `res_valid` pulses and the frequency when `freq_done` pulses.

Top module: `tcs_decoder`

## Requirements
- R1: `card_present` is 1 only when each of words 0, 1 and 2 has bits 31, 23, 15 and 7 set, and word 3 has bits 31 and 15 set and bits 14..0 clear.
- R2: When the marker check fails, every decoded output except `card_present` reads zero: the time fields, `bcd_err`, the flags, `pll_phase`, `freq_est` and `div_err`. `freq_done` pulses together with `res_valid`.
- R3: Word 0 holds four BCD fields, each a 3-bit tens digit above a 4-bit units digit: frames in bits 6..0, seconds in 14..8, minutes in 22..16 and hours in 30..24. Each output value is tens*10+units.
- R4: A units digit above 9 sets the `bcd_err` bit of its field (bit 0 frames, bit 1 seconds, bit 2 minutes, bit 3 hours). The binary value is still tens*10+units.
- R5: From word 1, `fps_code` comes from bits 11..10 (00=24, 01=25, 10=29.97, 11=30 fps), `drop_frame` from bit 9, `pal_in` from bit 6 and `ntsc_in` from bit 5.
- R6: From word 1, `wclk_valid` comes from bit 4, `ltc_valid` from bit 3 and `pll_locked` from bit 0.
- R7: `pll_phase` equals word 2 bits 6..0 plus word 2 bits 14..8 placed at bits 13..7.
- R8: For a nonzero phase, `freq_est` becomes floor(400000000 / phase). `freq_done` pulses exactly 29 cycles after the `res_valid` pulse.
- R9: With a card present and a zero phase, no division runs. `div_err` is 1, `freq_est` is 0, and `freq_done` pulses together with `res_valid`.
- R10: `res_valid` pulses for one cycle, one cycle after `load`. Results hold until the next load. A load during a division aborts it, and the new division's timing counts from the new load.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe: capture and decode the four words |
| word0 | input | 32 | Status word 0 (time fields) |
| word1 | input | 32 | Status word 1 (format and flags) |
| word2 | input | 32 | Status word 2 (split PLL phase) |
| word3 | input | 32 | Status word 3 (marker only) |
| res_valid | output | 1 | Decoded fields updated this cycle |
| card_present | output | 1 | Marker pattern matched |
| hours | output | 7 | Hours, binary |
| minutes | output | 7 | Minutes, binary |
| seconds | output | 7 | Seconds, binary |
| frames | output | 7 | Frames, binary |
| bcd_err | output | 4 | Non-decimal units digit per field |
| fps_code | output | 2 | Frame-rate code |
| drop_frame | output | 1 | Drop-frame active |
| pal_in | output | 1 | PAL video input seen |
| ntsc_in | output | 1 | NTSC video input seen |
| wclk_valid | output | 1 | Word clock input valid |
| ltc_valid | output | 1 | Timecode input valid |
| pll_locked | output | 1 | Card PLL locked |
| pll_phase | output | 14 | Reassembled PLL phase |
| freq_done | output | 1 | Frequency result updated this cycle |
| freq_est | output | 29 | Frequency estimate |
| div_err | output | 1 | Zero phase, no division done |

## Verification
A wrong presence decision shows at once, in the `res_valid` cycle: either every field is forced to zero when it should not be, or non-zero fields appear for an absent card. A slip in a BCD or flag bit position shows in that same cycle, on the wrong output. A fault in the divider state, such as a bad count, a stale remainder or a missed abort, shows only when `freq_done` arrives, 29 cycles later. It appears as a quotient outside the floor bound or as a pulse in the wrong cycle. So the bench times `freq_done` to the exact cycle as well as checking its value.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int TCS_WORD_W   = 32;
  localparam int TCS_HALF_W   = 7;
  localparam int TCS_PHASE_W  = 2 * TCS_HALF_W;
  localparam int TCS_NFIELD   = 4;
  localparam int TCS_DIVIDEND = 400_000_000;

  typedef enum logic [1:0] {
    FPS_24   = 2'b00,
    FPS_25   = 2'b01,
    FPS_2997 = 2'b10,
    FPS_30   = 2'b11
  } tcs_fps_e;

  typedef struct packed {
    logic                                   present;
    logic [TCS_NFIELD-1:0][TCS_HALF_W-1:0]  bin;
    logic [TCS_NFIELD-1:0]                  bcd_err;
    tcs_fps_e                               fps;
    logic                                   drop;
    logic                                   pal;
    logic                                   ntsc;
    logic                                   wclk;
    logic                                   ltc;
    logic                                   lock;
    logic [TCS_PHASE_W-1:0]                 phase;
    logic                                   div_err;
  } tcs_res_t;
endpackage

// File: rtl/tcs_bcd2bin.sv
module tcs_bcd2bin (
  input  logic [6:0] bcd,
  output logic [6:0] bin,
  output logic       bad
);
  logic [2:0] tens;
  logic [3:0] units;

  always_comb begin
    tens  = bcd[6:4];
    units = bcd[3:0];
    bin   = 7'(tens) * 7'd10 + 7'(units);
    bad   = (units > 4'd9);
  end
endmodule

// File: rtl/tcs_phase_div.sv
module tcs_phase_div #(
  parameter int NUM   = 400_000_000,
  parameter int NUM_W = $clog2(NUM + 1),
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             go,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [NUM_W-1:0] NUM_V = NUM_W'(NUM);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [NUM_W-1:0] dvd_q, dvd_d, acc_q, acc_d, res_q, res_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   trial;
  logic             qbit;

  always_comb begin
    busy_d = busy_q; cnt_d = cnt_q; rem_d = rem_q; den_d = den_q;
    dvd_d  = dvd_q;  acc_d = acc_q; res_d = res_q; done_d = 1'b0;
    trial  = {rem_q, dvd_q[NUM_W-1]};
    qbit   = (trial >= {1'b0, den_q});
    if (load) begin
      busy_d = go; cnt_d = '0; rem_d = '0; den_d = den;
      dvd_d  = NUM_V; acc_d = '0; res_d = '0;
    end else if (busy_q) begin
      rem_d = qbit ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
      dvd_d = {dvd_q[NUM_W-2:0], 1'b0};
      acc_d = {acc_q[NUM_W-2:0], qbit};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        busy_d = 1'b0;
        res_d  = {acc_q[NUM_W-2:0], qbit};
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; rem_q <= '0; den_q <= '0;
      dvd_q  <= '0;   acc_q <= '0; res_q <= '0; done_q <= 1'b0;
    end else begin
      busy_q <= busy_d; cnt_q <= cnt_d; rem_q <= rem_d; den_q <= den_d;
      dvd_q  <= dvd_d;  acc_q <= acc_d; res_q <= res_d; done_q <= done_d;
    end
  end

  assign quo  = res_q;
  assign done = done_q;

  // R8: the step counter never runs past the quotient width
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(NUM_W)));
  // R8: a partial remainder stays below the divisor
  a_r8_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/tcs_decoder.sv
module tcs_decoder
  import tcs_pkg::*;
#(
  parameter int DIVIDEND = TCS_DIVIDEND,
  parameter int FREQ_W   = $clog2(DIVIDEND + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [TCS_WORD_W-1:0]  word0,
  input  logic [TCS_WORD_W-1:0]  word1,
  input  logic [TCS_WORD_W-1:0]  word2,
  input  logic [TCS_WORD_W-1:0]  word3,
  output logic                   res_valid,
  output logic                   card_present,
  output logic [TCS_HALF_W-1:0]  hours,
  output logic [TCS_HALF_W-1:0]  minutes,
  output logic [TCS_HALF_W-1:0]  seconds,
  output logic [TCS_HALF_W-1:0]  frames,
  output logic [TCS_NFIELD-1:0]  bcd_err,
  output logic [1:0]             fps_code,
  output logic                   drop_frame,
  output logic                   pal_in,
  output logic                   ntsc_in,
  output logic                   wclk_valid,
  output logic                   ltc_valid,
  output logic                   pll_locked,
  output logic [TCS_PHASE_W-1:0] pll_phase,
  output logic                   freq_done,
  output logic [FREQ_W-1:0]      freq_est,
  output logic                   div_err
);
  localparam int NMARK = 3;

  logic [NMARK-1:0][TCS_WORD_W-1:0]       mark_words;
  logic [NMARK-1:0]                       mark_ok;
  logic                                   tail_ok, pres_w;
  logic [TCS_NFIELD-1:0][TCS_HALF_W-1:0]  bin_w;
  logic [TCS_NFIELD-1:0]                  bad_w;
  logic [TCS_PHASE_W-1:0]                 phase_w;
  tcs_res_t                               res_q, res_d;
  logic                                   vld_q, imm_q, imm_d, div_go, div_done;
  logic                                   unused_bits;

  assign mark_words = {word2, word1, word0};

  generate
    for (genvar g = 0; g < NMARK; g++) begin : g_mark
      assign mark_ok[g] = mark_words[g][31] & mark_words[g][23]
                        & mark_words[g][15] & mark_words[g][7];
    end
    for (genvar f = 0; f < TCS_NFIELD; f++) begin : g_field
      tcs_bcd2bin u_bcd (
        .bcd (word0[f*8 +: TCS_HALF_W]),
        .bin (bin_w[f]),
        .bad (bad_w[f])
      );
    end
  endgenerate

  assign tail_ok = word3[31] & word3[15] & (word3[14:0] == 15'd0);
  assign pres_w  = (&mark_ok) & tail_ok;
  assign phase_w = {word2[14:8], word2[6:0]};
  assign div_go  = load & pres_w & (phase_w != '0);

  always_comb begin
    res_d = res_q;
    imm_d = 1'b0;
    if (load) begin
      res_d         = '0;
      res_d.present = pres_w;
      imm_d         = ~div_go;
      if (pres_w) begin
        res_d.bin     = bin_w;
        res_d.bcd_err = bad_w;
        res_d.fps     = tcs_fps_e'(word1[11:10]);
        res_d.drop    = word1[9];
        res_d.pal     = word1[6];
        res_d.ntsc    = word1[5];
        res_d.wclk    = word1[4];
        res_d.ltc     = word1[3];
        res_d.lock    = word1[0];
        res_d.phase   = phase_w;
        res_d.div_err = (phase_w == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      imm_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= load;
      imm_q <= imm_d;
    end
  end

  tcs_phase_div #(
    .NUM   (DIVIDEND),
    .NUM_W (FREQ_W),
    .DEN_W (TCS_PHASE_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .go    (div_go),
    .den   (phase_w),
    .quo   (freq_est),
    .done  (div_done)
  );

  assign res_valid    = vld_q;
  assign card_present = res_q.present;
  assign frames       = res_q.bin[0];
  assign seconds      = res_q.bin[1];
  assign minutes      = res_q.bin[2];
  assign hours        = res_q.bin[3];
  assign bcd_err      = res_q.bcd_err;
  assign fps_code     = res_q.fps;
  assign drop_frame   = res_q.drop;
  assign pal_in       = res_q.pal;
  assign ntsc_in      = res_q.ntsc;
  assign wclk_valid   = res_q.wclk;
  assign ltc_valid    = res_q.ltc;
  assign pll_locked   = res_q.lock;
  assign pll_phase    = res_q.phase;
  assign div_err      = res_q.div_err;
  assign freq_done    = imm_q | div_done;

  assign unused_bits = ^{word1[30:24], word1[22:16], word1[14:12], word1[8],
                         word1[2:1], word2[30:24], word2[22:16], word3[30:16]};

  // R2: an absent card reports nothing but its absence
  a_r2_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !card_present) |-> (hours == '0 && minutes == '0 &&
      seconds == '0 && frames == '0 && bcd_err == '0 && pll_phase == '0 &&
      !pll_locked && freq_done && freq_est == '0 && !div_err));
  // R8: the finished quotient is the floor of dividend over phase
  a_r8_floor_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_done && card_present && !div_err) |->
      ((64'(freq_est) * 64'(pll_phase) <= 64'(DIVIDEND)) &&
       ((64'(freq_est) + 64'd1) * 64'(pll_phase) > 64'(DIVIDEND))));
  // R9: zero phase ends at once with the error flag and no quotient
  a_r9_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && card_present && pll_phase == '0) |->
      (div_err && freq_done && freq_est == '0));
  // R10: the result strobe is a single-cycle pulse
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !load) |=> !res_valid);
  // R10: decoded fields hold between loads
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(hours) && $stable(pll_phase) && $stable(card_present)));
endmodule

// File: tb/tb_tcs_decoder.sv
`timescale 1ns/1ps
module tb_tcs_decoder;
  localparam int DIV_LAT = 29;

  typedef struct packed {
    logic [31:0] q0, q1, q2, q3;
    logic        pres;
    logic [13:0] ph;
    logic [28:0] fq;
    logic        derr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'hA3D9D8A9, 32'h80808EB1, 32'h808087E8, 32'h80008000, 1'b1, 14'd1000,  29'd400000,    1'b0},
    '{32'h8F80809A, 32'h80808080, 32'h80808081, 32'h80008000, 1'b1, 14'd1,     29'd400000000, 1'b0},
    '{32'h80808080, 32'h808088C8, 32'h8080FFFF, 32'h80008000, 1'b1, 14'd16383, 29'd24415,     1'b0},
    '{32'hA3D9D8A9, 32'h80808EB1, 32'h80808080, 32'h80008000, 1'b1, 14'd0,     29'd0,         1'b1},
    '{32'hA3D9D8A9, 32'h80808EB1, 32'h80808083, 32'h80008008, 1'b0, 14'd0,     29'd0,         1'b0},
    '{32'hA3D9D8A9, 32'h00808EB1, 32'h80808083, 32'h80008000, 1'b0, 14'd0,     29'd0,         1'b0},
    '{32'h80808080, 32'h80808080, 32'h80808083, 32'h80008000, 1'b1, 14'd3,     29'd133333333, 1'b0}
  };

  logic clk, rst_n, load;
  logic [31:0] word0, word1, word2, word3;
  logic res_valid, card_present, drop_frame, pal_in, ntsc_in;
  logic wclk_valid, ltc_valid, pll_locked, freq_done, div_err;
  logic [6:0] hours, minutes, seconds, frames;
  logic [3:0] bcd_err;
  logic [1:0] fps_code;
  logic [13:0] pll_phase;
  logic [28:0] freq_est;
  int n_chk, n_bad;

  tcs_decoder dut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .word0(word0), .word1(word1), .word2(word2), .word3(word3),
    .res_valid(res_valid), .card_present(card_present),
    .hours(hours), .minutes(minutes), .seconds(seconds), .frames(frames),
    .bcd_err(bcd_err), .fps_code(fps_code), .drop_frame(drop_frame),
    .pal_in(pal_in), .ntsc_in(ntsc_in), .wclk_valid(wclk_valid),
    .ltc_valid(ltc_valid), .pll_locked(pll_locked), .pll_phase(pll_phase),
    .freq_done(freq_done), .freq_est(freq_est), .div_err(div_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] bcd_val(input logic [31:0] w, input int f);
    return 7'(w[f*8+4 +: 3]) * 7'd10 + 7'(w[f*8 +: 4]);
  endfunction

  function automatic logic [3:0] bcd_bad(input logic [31:0] w);
    logic [3:0] b;
    for (int f = 0; f < 4; f++) b[f] = (w[f*8 +: 4] > 4'd9);
    return b;
  endfunction

  task automatic drive(input vec_t v);
    @(negedge clk);
    load = 1'b1; word0 = v.q0; word1 = v.q1; word2 = v.q2; word3 = v.q3;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_freq(input string req, input vec_t v);
    int seen;
    seen = 0;
    for (int n = 1; n <= DIV_LAT + 5; n++) begin
      @(negedge clk);
      if (freq_done && seen == 0) seen = n;
    end
    check({req, " R8 done latency"}, 64'(seen), 64'(DIV_LAT));
    check({req, " R8 quotient"}, 64'(freq_est), 64'(v.fq));
  endtask

  task automatic run_vec(input vec_t v);
    logic [27:0] ef;
    logic [9:0]  eflag;
    drive(v);
    check("R10 res_valid pulse", 64'(res_valid), 64'd1);
    check("R1 presence", 64'(card_present), 64'(v.pres));
    ef    = v.pres ? {bcd_val(v.q0, 3), bcd_val(v.q0, 2), bcd_val(v.q0, 1), bcd_val(v.q0, 0)} : '0;
    eflag = v.pres ? {bcd_bad(v.q0), v.q1[11:10], v.q1[9], v.q1[6], v.q1[5], v.q1[4]} : '0;
    check("R2 R3 time fields", 64'({hours, minutes, seconds, frames}), 64'(ef));
    check("R4 R5 bcd_err and format flags",
          64'({bcd_err, fps_code, drop_frame, pal_in, ntsc_in, wclk_valid}), 64'(eflag));
    check("R6 ltc and lock", 64'({ltc_valid, pll_locked}),
          v.pres ? 64'({v.q1[3], v.q1[0]}) : 64'd0);
    check("R7 phase", 64'(pll_phase), 64'(v.ph));
    check("R9 div_err", 64'(div_err), 64'(v.derr));
    if (v.pres && v.ph != 0) begin
      check("R8 no early done", 64'(freq_done), 64'd0);
      wait_freq("vec", v);
    end else begin
      check("R2 R9 immediate done", 64'({freq_done, freq_est}), 64'({1'b1, 29'd0}));
      @(negedge clk);
      check("R10 single pulse", 64'({res_valid, freq_done}), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; load = 1'b0;
    word0 = '0; word1 = '0; word2 = '0; word3 = '0;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", 64'({res_valid, card_present, freq_done, div_err, pll_phase}), 64'd0);
    check("R11 reset freq", 64'(freq_est), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: held results, no further strobes
    repeat (4) @(negedge clk);
    check("R10 hold fields", 64'({hours, pll_phase, card_present}),
          64'({7'd0, 14'd3, 1'b1}));
    check("R10 hold freq", 64'({res_valid, freq_done, freq_est}),
          64'({1'b0, 1'b0, 29'd133333333}));

    // R10: reload mid-division aborts and restarts timing
    drive(VECS[1]);
    repeat (5) @(negedge clk);
    check("R10 abort: no done yet", 64'(freq_done), 64'd0);
    drive(VECS[0]);
    check("R10 second res_valid", 64'(res_valid), 64'd1);
    wait_freq("abort", VECS[0]);

    // R11: reset during a division clears everything
    drive(VECS[6]);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 mid-run reset", 64'({card_present, pll_phase, freq_est, freq_done}), 64'd0);
    rst_n = 1'b1;
    repeat (DIV_LAT + 3) @(negedge clk);
    check("R11 no stale done", 64'({freq_done, freq_est}), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule